// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that software programs through four 32-bit registers on a simple register bus. Each access takes one cycle. A selectable prescaler slows the bus clock. The prescaled ticks then drive a down-counter, which is loaded from a coarse 12-bit reload field. If software does not restart the counter before it reaches zero, the block reacts in one of two ways. It can drive a reset pulse of programmable length, or it can raise a level interrupt, or it can do both, depending on the enables.

The configuration registers accept a write only when that write carries its own key value. The counter restarts only when one exact 32-bit value is written to the restart register. Because of this, a runaway program that writes random data is unlikely to reconfigure the watchdog or to keep it alive.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, every register reads as zero, the counter is stopped, and both the reset and interrupt outputs are low.
- R2: A write to byte offset 0x0 (mode) takes effect only when data bits [23:12] equal 0xABC. The stored mode fields are enable in bit 0, reset-enable in bit 1, interrupt-enable in bit 2 and pulse length in bits [6:4]. A read of offset 0x0 returns these fields with every other bit, including the key field, read as zero.
- R3: A write to byte offset 0x4 (control) takes effect only when data bits [25:14] equal 0x248, which is the word 0x00920000. The stored fields are the reload value in bits [13:2] and the prescaler select in bits [1:0]. A read returns these fields with every other bit read as zero.
- R4: A write to byte offset 0x8 reloads the counter only when the data equals exactly 0x00001999. Any other value leaves the countdown schedule unchanged. Offset 0x8 always reads as zero.
- R5: Timeout timing is measured from the clock edge that captured the restart or enabling write. The status flag rises at edge N*D+1, where N = reload * 2^UNIT_W (UNIT_W defaults to 12, so one reload unit is 4096 ticks). The divisor D is set by the prescaler select: 8 for 0, 64 for 1, 512 for 2 and 4096 for 3.
- R6: Status bit 0 at byte offset 0xC is set on timeout. It stays set until a valid restart or an enabling mode write clears it.
- R7: The interrupt output equals the status flag while both the enable bit and the interrupt-enable bit are set. Otherwise it is low.
- R8: If reset-enable is set when a timeout occurs, the reset output goes high on the same edge that sets the status flag. It stays high for 2 << len clock cycles, where len is the pulse-length field: 0 gives 2 cycles, 3 gives 16 cycles and 7 gives 256 cycles.
- R9: A keyed mode write that clears the enable bit freezes the counter. After that write, no timeout, no interrupt and no reset pulse occurs.
- R10: A keyed mode write that sets the enable bit while the timer is stopped reloads the counter, clears the status flag and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data, including the key fields |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| wd_rst_o | output | 1 | Timeout reset pulse, active high |
| wd_irq_o | output | 1 | Timeout interrupt level |

## Verification
A wrong internal state here usually shows as a timeout edge that arrives too early or too late. For example, a prescaler that skips a count or a counter that loads the wrong bits moves the status rise away from edge N*D+1. The bench therefore checks the status flag one edge before and exactly at the predicted edge. A stuck status flag or a mis-decoded key is visible within a single read. A faulty pulse counter shows as a reset output whose high time is not 2 << len cycles. The bench measures that high time directly after each timeout.

// File: rtl/wdt_key_pkg.sv
// Shared constants, register layout and helpers for the keyed watchdog.
// Assumes a 32-bit data bus with byte offsets for the four registers.
package wdt_key_pkg;

    localparam int DATA_W = 32;

    // Key values that unlock writes to the configuration registers
    localparam logic [11:0] MODE_KEY    = 12'hABC;
    localparam logic [11:0] CTRL_KEY    = 12'h248;
    localparam logic [31:0] RESTART_KEY = 32'h0000_1999;

    // Byte offsets of the registers
    localparam logic [3:0] OFF_MODE    = 4'h0;
    localparam logic [3:0] OFF_CTRL    = 4'h4;
    localparam logic [3:0] OFF_RESTART = 4'h8;
    localparam logic [3:0] OFF_STATUS  = 4'hC;

    // Stored mode fields
    typedef struct packed {
        logic [2:0] pulse_len;
        logic       irq_en;
        logic       rst_en;
        logic       run;
    } mode_cfg_t;

    // log2 of the prescaler divisor for each select code
    function automatic int unsigned div_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3;
            2'd1:    return 6;
            2'd2:    return 9;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/wdt_cfg_regs.sv
// Register file of the keyed watchdog.
// Holds the mode and control fields, checks the write keys, decodes the
// restart value and builds read data. Assumes single-cycle accesses.
module wdt_cfg_regs
    import wdt_key_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int RELOAD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                expired,
    output mode_cfg_t           mode_q,
    output logic [RELOAD_W-1:0] reload_q,
    output logic [1:0]          sel_q,
    output logic                restart_hit,
    output logic                start_evt,
    output logic [DATA_W-1:0]   rdata
);

    localparam int RELOAD_LSB = 2;
    localparam int CKEY_LSB   = RELOAD_LSB + RELOAD_W;
    localparam int MKEY_LSB   = 12;

    logic wr_req, rd_req;
    logic mode_wr, ctrl_wr;
    mode_cfg_t mode_new;

    // Decode the access type and check the write keys
    always_comb begin
        wr_req   = bus_valid && bus_write;
        rd_req   = bus_valid && !bus_write;
        mode_wr  = wr_req && (bus_addr == ADDR_W'(OFF_MODE))
                   && (bus_wdata[MKEY_LSB +: 12] == MODE_KEY);
        ctrl_wr  = wr_req && (bus_addr == ADDR_W'(OFF_CTRL))
                   && (bus_wdata[CKEY_LSB +: 12] == CTRL_KEY);
        restart_hit = wr_req && (bus_addr == ADDR_W'(OFF_RESTART))
                   && (bus_wdata == RESTART_KEY);
        mode_new = '{pulse_len: bus_wdata[6:4], irq_en: bus_wdata[2],
                     rst_en: bus_wdata[1], run: bus_wdata[0]};
        start_evt = mode_wr && mode_new.run && !mode_q.run;
    end

    // Store the mode fields on a keyed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_new;
        end
    end

    // Store the control fields on a keyed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            sel_q    <= '0;
        end else if (ctrl_wr) begin
            reload_q <= bus_wdata[RELOAD_LSB +: RELOAD_W];
            sel_q    <= bus_wdata[1:0];
        end
    end

    // Build read data; key fields and the restart register read as zero
    always_comb begin
        rdata = '0;
        if (rd_req) begin
            if (bus_addr == ADDR_W'(OFF_MODE)) begin
                rdata[6:4] = mode_q.pulse_len;
                rdata[2]   = mode_q.irq_en;
                rdata[1]   = mode_q.rst_en;
                rdata[0]   = mode_q.run;
            end else if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                rdata[RELOAD_LSB +: RELOAD_W] = reload_q;
                rdata[1:0] = sel_q;
            end else if (bus_addr == ADDR_W'(OFF_STATUS)) begin
                rdata[0] = expired;
            end
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
// Clock prescaler: produces a one-cycle tick every 2^div_shift(sel) clocks
// while running. A clear restarts the phase. Assumes PRE_W >= 12.
module wdt_prescaler
    import wdt_key_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    // Terminal count for the selected divisor
    always_comb begin
        limit = PRE_W'((1 << div_shift(sel)) - 1);
        tick  = run && !clear && (pre_cnt == limit);
    end

    // Advance the phase counter; wrap on tick, hold at zero when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clear || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_downcount.sv
// Timeout counter: loads reload * 2^UNIT_W, counts down one per tick and
// sets a sticky expired flag one edge after reaching zero. Assumes load
// and tick are mutually exclusive (the prescaler masks tick on clear).
module wdt_downcount #(
    parameter int RELOAD_W = 12,
    parameter int UNIT_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                tick,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expired,
    output logic                expire_evt
);

    localparam int CNT_W = RELOAD_W + UNIT_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Load value and the edge on which the flag sets
    always_comb begin
        load_val   = {reload, {UNIT_W{1'b0}}};
        expire_evt = run && !load && !expired && (cnt == '0);
    end

    // Count down while running; reload and clear on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            expired <= 1'b0;
        end else begin
            if (run && tick && (cnt != '0)) begin
                cnt <= cnt - 1'b1;
            end
            if (expire_evt) begin
                expired <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
// Reset pulse generator: on fire, drives its output for 2 << len clocks.
// Assumes fire is a single-cycle event; a new fire restarts the length.
module wdt_pulse #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    output logic             pulse_o
);

    localparam int PW = (1 << LEN_W) + 1;

    logic [PW-1:0] remain;

    // Load the pulse length or count down the remaining cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (fire) begin
            remain <= PW'(2) << len;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // The output is high while cycles remain
    always_comb pulse_o = (remain != '0);

endmodule

// File: rtl/keyed_wdt.sv
// Top of the key-protected watchdog timer. Connects the register file,
// prescaler, down-counter and reset pulse generator. Assumes one bus clock
// domain and synchronous active-low reset.
module keyed_wdt
    import wdt_key_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int RELOAD_W = 12,
    parameter int UNIT_W   = 12,
    parameter int LEN_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_rst_o,
    output logic              wd_irq_o
);

    localparam int PRE_W = 12;

    mode_cfg_t           mode_q;
    logic [RELOAD_W-1:0] reload_q;
    logic [1:0]          sel_q;
    logic                restart_hit, start_evt, reload_evt;
    logic                tick, expired, expire_evt;

    wdt_cfg_regs #(.ADDR_W(ADDR_W), .RELOAD_W(RELOAD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expired(expired),
        .mode_q(mode_q), .reload_q(reload_q), .sel_q(sel_q),
        .restart_hit(restart_hit), .start_evt(start_evt), .rdata(bus_rdata)
    );

    // Any reload also restarts the prescaler phase
    always_comb reload_evt = restart_hit || start_evt;

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(mode_q.run), .clear(reload_evt),
        .sel(sel_q), .tick(tick)
    );

    wdt_downcount #(.RELOAD_W(RELOAD_W), .UNIT_W(UNIT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(mode_q.run), .tick(tick),
        .load(reload_evt), .reload(reload_q), .expired(expired),
        .expire_evt(expire_evt)
    );

    wdt_pulse #(.LEN_W(LEN_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(expire_evt && mode_q.rst_en),
        .len(mode_q.pulse_len), .pulse_o(wd_rst_o)
    );

    // Interrupt level follows the flag while running with interrupts on
    always_comb wd_irq_o = expired && mode_q.irq_en && mode_q.run;

endmodule

// File: rtl/keyed_wdt_chk.sv
// Assertion checker for keyed_wdt, attached with bind below.
module keyed_wdt_chk #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [11:0]       mode_key,
    input logic [5:0]        mode_bits,
    input logic              run,
    input logic              irq_en,
    input logic              reload_evt,
    input logic              expired,
    input logic [CNT_W-1:0]  cnt,
    input logic              wd_rst_o,
    input logic              wd_irq_o
);

    // R2
    mode_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(4'h0) && mode_key != 12'hABC)
        |=> $stable(mode_bits));

    // R6
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !reload_evt) |=> expired);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq_o |-> (run && irq_en && expired));

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_o) |-> $rose(expired));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload_evt) |=> $stable(cnt));

endmodule

bind keyed_wdt keyed_wdt_chk #(.ADDR_W(ADDR_W), .CNT_W(RELOAD_W + UNIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .mode_key(bus_wdata[23:12]), .mode_bits(mode_q),
    .run(mode_q.run), .irq_en(mode_q.irq_en), .reload_evt(reload_evt),
    .expired(expired), .cnt(u_cnt.cnt), .wd_rst_o(wd_rst_o), .wd_irq_o(wd_irq_o)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;

    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_rst_o, wd_irq_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdt #(.ADDR_W(4), .RELOAD_W(12), .UNIT_W(UNIT), .LEN_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_rst_o(wd_rst_o), .wd_irq_o(wd_irq_o)
    );

    function automatic int exp_cycles(int reload, int sel);
        return reload * (1 << UNIT) * (8 << (3 * sel)) + 1;
    endfunction

    function automatic int exp_pulse(int len);
        return 2 << len;
    endfunction

    function automatic logic [31:0] mode_word(logic [11:0] key, int len,
                                              bit irq, bit rst, bit en);
        return {8'h0, key, 5'h0, 3'(len), 1'b0, irq, rst, en};
    endfunction

    function automatic logic [31:0] ctrl_word(logic [11:0] key, int reload, int sel);
        return {6'h0, key, 12'(reload), 2'(sel)};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] addr, logic [31:0] data);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] addr, output logic [31:0] data);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr;
        #1;
        data = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic start_run(int reload, int sel, int len, bit irq, bit rst);
        wr(4'h0, mode_word(12'hABC, 0, 0, 0, 0));
        wr(4'h4, ctrl_word(12'h248, reload, sel));
        wr(4'h0, mode_word(12'hABC, len, irq, rst, 1));
    endtask

    // Check expiry edge and the actions; entered at k=0 after the start write
    task automatic expect_timeout(int t, bit irq, bit rst, int len);
        logic [31:0] s;
        int n;
        repeat (t - 1) @(negedge clk);
        rd(4'hC, s);
        check("R5 status before timeout", s, 32'h0);
        check("R8 no pulse before timeout", 32'(wd_rst_o), 32'h0);
        @(negedge clk);
        rd(4'hC, s);
        check("R5 status at timeout", s, 32'h1);
        check("R7 irq at timeout", 32'(wd_irq_o), 32'(irq));
        check("R8 pulse start", 32'(wd_rst_o), 32'(rst));
        if (rst) begin
            n = 0;
            while (wd_rst_o && n < 400) begin
                n++;
                @(negedge clk);
            end
            check("R8 pulse length", 32'(n), 32'(exp_pulse(len)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got hang expected end");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit saw;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, d); check("R1 mode after reset", d, 0);
        rd(4'h4, d); check("R1 ctrl after reset", d, 0);
        rd(4'hC, d); check("R1 status after reset", d, 0);
        check("R1 outputs after reset", {30'h0, wd_rst_o, wd_irq_o}, 0);

        // R2 mode key
        wr(4'h0, mode_word(12'hABD, 3, 1, 1, 1));
        rd(4'h0, d); check("R2 bad key ignored", d, 0);
        wr(4'h0, mode_word(12'hABC, 5, 1, 0, 0));
        rd(4'h0, d); check("R2 keyed write readback", d, 32'h54);

        // R3 control key
        wr(4'h4, ctrl_word(12'h249, 12'hABC, 3));
        rd(4'h4, d); check("R3 bad key ignored", d, 0);
        wr(4'h4, ctrl_word(12'h248, 12'h5A5, 2));
        rd(4'h4, d); check("R3 keyed write readback", d, 32'h1696);
        rd(4'h8, d); check("R4 restart reads zero", d, 0);

        // R4 wrong restart values do not move the schedule, R6 hold and clear
        start_run(1, 0, 0, 1, 0);
        repeat (9) @(negedge clk);
        wr(4'h8, 32'h0000_1998);
        wr(4'h8, 32'h0001_1999);
        repeat (exp_cycles(1, 0) - 12) @(negedge clk);
        rd(4'hC, d); check("R4 wrong key no reload (pre)", d, 0);
        @(negedge clk);
        rd(4'hC, d); check("R4 wrong key no reload (at)", d, 1);
        repeat (50) @(negedge clk);
        rd(4'hC, d); check("R6 status held", d, 1);
        wr(4'h8, 32'h0000_1999);
        rd(4'hC, d); check("R6 restart clears status", d, 0);
        check("R7 irq low after restart", 32'(wd_irq_o), 0);
        expect_timeout(exp_cycles(1, 0), 1, 0, 0);

        // R4 restart mid count pushes the deadline
        start_run(1, 0, 0, 0, 0);
        repeat (20) @(negedge clk);
        wr(4'h8, 32'h0000_1999);
        expect_timeout(exp_cycles(1, 0), 0, 0, 0);

        // R9 disable freezes, R10 re-enable reloads
        start_run(1, 0, 2, 1, 1);
        repeat (5) @(negedge clk);
        wr(4'h0, mode_word(12'hABC, 2, 1, 1, 0));
        saw = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wd_rst_o || wd_irq_o) saw = 1;
        end
        rd(4'hC, d); check("R9 no timeout while disabled", d, 0);
        check("R9 no action while disabled", 32'(saw), 0);
        wr(4'h0, mode_word(12'hABC, 2, 1, 1, 1));
        expect_timeout(exp_cycles(1, 0), 1, 1, 2);

        // R8 extreme pulse lengths, R7 irq masked
        start_run(0, 0, 7, 0, 1);
        expect_timeout(exp_cycles(0, 0), 0, 1, 7);
        start_run(0, 1, 0, 0, 1);
        expect_timeout(exp_cycles(0, 1), 0, 1, 0);

        // R5 the slower divisors
        start_run(1, 2, 3, 1, 1);
        expect_timeout(exp_cycles(1, 2), 1, 1, 3);
        start_run(1, 3, 1, 0, 1);
        expect_timeout(exp_cycles(1, 3), 0, 1, 1);

        // R5 R7 R8 random runs
        for (int it = 0; it < 12; it++) begin
            int rl, sl, ln;
            bit ie, re;
            rl = $urandom_range(0, 3);
            sl = $urandom_range(0, 1);
            ln = $urandom_range(0, 7);
            ie = 1'($urandom_range(0, 1));
            re = 1'($urandom_range(0, 1));
            start_run(rl, sl, ln, ie, re);
            expect_timeout(exp_cycles(rl, sl), ie, re, ln);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule